// File: doc/BRIEF.md
# SPI Flash Memory-Mapped Access Engine

This engine turns one read or write on a simple memory-mapped bus port into a complete serial flash transaction. When a request is accepted, chip select goes low and the engine shifts out a command byte. It then sends the flash array address in one to four bytes, adds an optional run of dummy bytes, and moves a fixed number of data bytes. Chip select is then released and the bus port is told that the access is done.

The configuration port sets the command byte for reads and the one for writes, the address length, the dummy count, whether reads use four lanes, and the serial clock divider. Command, address and dummy bytes always travel on lane 0. Only read data may use all four lanes. The engine issues no commands other than the two configured array-access commands. The configuration and the bus inputs are captured when a request is accepted, so later changes do not disturb a transaction already in flight.

Top module: `spi_flash_mmap`

## Requirements
- R1: The first byte clocked out after `spi_cs_n` falls is `cfg_rd_cmd` when `bus_we`=0 and `cfg_wr_cmd` when `bus_we`=1. It is sent MSB first on `spi_dout[0]`.
- R2: After the command, `cfg_addr_len`+1 address bytes are sent on `spi_dout[0]`: 00 gives 1 byte and 11 gives 4 bytes. They are the low-order bytes of `bus_addr`, most significant of those first, each MSB first.
- R3: `cfg_dummy` bytes (0 to 15) of zeros follow on `spi_dout[0]`. The total count of rising `spi_sclk` edges is 8·(2+`cfg_addr_len`+`cfg_dummy`) plus the data-phase edges: 8 per byte for single lane and 2 per byte for quad read.
- R4: Each access moves DATA_BYTES (default 4) whole bytes while `spi_cs_n` stays low. On a write, `bus_wdata[7:0]` goes first, then the next byte up, and each byte is sent MSB first on `spi_dout[0]`.
- R5: On a single-lane read, `spi_din[1]` is sampled on each rising `spi_sclk` edge, MSB first. The first byte received lands in `bus_rdata[7:0]`, and later bytes fill the bytes above it.
- R6: When `cfg_quad_rd`=1 and the access is a read, each data-phase clock receives one nibble on `spi_din[3:0]`, high nibble first, and `spi_doe` is 0000. In every other active clock `spi_doe` is 0001. `cfg_quad_rd` has no effect on writes.
- R7: `bus_ready` is a one-cycle pulse in the cycle after the final rising `spi_sclk` edge. `spi_cs_n` goes high in that same cycle, and `bus_rdata` is valid there.
- R8: The SPI link uses mode 0. `spi_sclk` is low whenever `spi_cs_n` is high, and data is sampled on rising edges.
- R9: The first rising `spi_sclk` edge comes `cfg_clk_div`+1 system cycles after `spi_cs_n` falls. Later rising edges are spaced 2·(`cfg_clk_div`+1) cycles apart.
- R10: After reset, `spi_cs_n`=1, `spi_sclk`=0, `bus_ready`=0 and `spi_doe`=0000.
- R11: A request is accepted when `bus_req` is high and the engine is idle. Changes to the configuration or bus inputs after acceptance do not affect the transaction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rd_cmd | input | 8 | Command byte for reads |
| cfg_wr_cmd | input | 8 | Command byte for writes |
| cfg_addr_len | input | 2 | Address bytes minus one |
| cfg_dummy | input | DUMMY_W | Dummy byte count |
| cfg_quad_rd | input | 1 | Receive read data on four lanes |
| cfg_clk_div | input | DIV_W | Serial clock half period minus one, in system cycles |
| bus_req | input | 1 | Access request, held until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Flash array address |
| bus_wdata | input | 8·DATA_BYTES | Write data |
| bus_rdata | output | 8·DATA_BYTES | Read data |
| bus_ready | output | 1 | Access complete pulse |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_dout | output | 4 | Lane output values |
| spi_doe | output | 4 | Lane output enables |
| spi_din | input | 4 | Lane input values |

## Verification
Two events share a clock edge when requests arrive back to back. The engine returns to idle after its ready pulse, and a new request is accepted on that same edge, so chip select rises and falls with only one system cycle high in between. The bench provokes this by holding the request high across the ready pulse, with new bus values applied straight away. It then judges the second transaction by its command, address, timing and data against the model, and checks that the first one finished correctly. A second overlap is covered by changing every configuration and bus input in the cycle right after acceptance, and confirming that the wire sequence still follows the values captured at acceptance.

// File: rtl/sfm_pkg.sv
// Shared constants and types for the SPI flash memory-mapped engine.
// Assumes a fixed 32-bit flash address space (at most four address bytes).
package sfm_pkg;
    localparam int ADDR_BYTES = 4;
    localparam int ADDR_W     = 8 * ADDR_BYTES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_FIN
    } sfm_state_e;
endpackage

// File: rtl/sfm_clkdiv.sv
// Serial clock tick generator: while run is high, it emits one tick every
// div+1 system cycles, and each tick toggles the serial clock.
// Assumes div is held stable while run is high.
module sfm_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Count system cycles within one serial half period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end

    // R9
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= div));
endmodule

// File: rtl/sfm_seq.sv
// Transaction sequencer: captures one bus access with its configuration,
// then walks the command, address, dummy and data phases in SPI mode 0.
// Outputs change only on falling ticks, and inputs are sampled on rising
// ticks. Assumes bus_req is held until bus_ready and dropped after it.
module sfm_seq
    import sfm_pkg::*;
#(
    parameter int DATA_BYTES = 4,
    parameter int DUMMY_W    = 4,
    parameter int DIV_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              cfg_rd_cmd,
    input  logic [7:0]              cfg_wr_cmd,
    input  logic [1:0]              cfg_addr_len,
    input  logic [DUMMY_W-1:0]      cfg_dummy,
    input  logic                    cfg_quad_rd,
    input  logic [DIV_W-1:0]        cfg_clk_div,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [8*DATA_BYTES-1:0] bus_wdata,
    output logic [8*DATA_BYTES-1:0] bus_rdata,
    output logic                    bus_ready,
    output logic                    spi_cs_n,
    output logic                    spi_sclk,
    output logic [3:0]              spi_dout,
    output logic [3:0]              spi_doe,
    input  logic [3:0]              spi_din,
    input  logic                    tick,
    output logic                    run,
    output logic [DIV_W-1:0]        lat_div
);
    localparam int DATA_W = 8 * DATA_BYTES;
    localparam int DB_W   = $clog2(DATA_BYTES + 1);
    localparam int CNT_W  = (DUMMY_W > DB_W) ? DUMMY_W : DB_W;

    sfm_state_e          state;
    logic [7:0]          sr;
    logic [7:0]          rx;
    logic [2:0]          bit_cnt;
    logic [CNT_W-1:0]    byte_cnt;
    logic                byte_end;
    logic [ADDR_W-1:0]   addr_sr;
    logic [DATA_W-1:0]   wsr;
    logic [DATA_W-1:0]   rsr;
    logic                lat_we;
    logic                lat_quad;
    logic [1:0]          lat_alen;
    logic [DUMMY_W-1:0]  lat_dummy;

    logic                quad_data;
    logic                quad_lane;
    logic                last_bit;
    logic [7:0]          rx_next;

    // Decode lane mode and end-of-byte for the current rising tick.
    always_comb begin
        quad_data = lat_quad && !lat_we && (state == ST_DATA);
        quad_lane = lat_quad && !lat_we && (state == ST_DATA || state == ST_FIN);
        rx_next   = quad_data ? {rx[3:0], spi_din} : {rx[6:0], spi_din[1]};
        last_bit  = quad_data ? (bit_cnt == 3'd1) : (bit_cnt == 3'd7);
    end

    assign run      = (state != ST_IDLE);
    assign spi_dout = {3'b000, sr[7]};
    assign spi_doe  = (run && !quad_lane) ? 4'b0001 : 4'b0000;

    // Main sequencer: accept, shift phases, finish and report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            spi_cs_n  <= 1'b1;
            spi_sclk  <= 1'b0;
            bus_ready <= 1'b0;
            bus_rdata <= '0;
            sr        <= '0;
            rx        <= '0;
            bit_cnt   <= '0;
            byte_cnt  <= '0;
            byte_end  <= 1'b0;
            addr_sr   <= '0;
            wsr       <= '0;
            rsr       <= '0;
            lat_we    <= 1'b0;
            lat_quad  <= 1'b0;
            lat_alen  <= '0;
            lat_dummy <= '0;
            lat_div   <= '0;
        end else begin
            bus_ready <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (bus_req) begin
                        lat_we    <= bus_we;
                        lat_quad  <= cfg_quad_rd;
                        lat_alen  <= cfg_addr_len;
                        lat_dummy <= cfg_dummy;
                        lat_div   <= cfg_clk_div;
                        sr        <= bus_we ? cfg_wr_cmd : cfg_rd_cmd;
                        addr_sr   <= bus_addr << {(2'd3 - cfg_addr_len), 3'b000};
                        wsr       <= bus_wdata;
                        rx        <= '0;
                        bit_cnt   <= '0;
                        byte_cnt  <= '0;
                        byte_end  <= 1'b0;
                        spi_cs_n  <= 1'b0;
                        state     <= ST_CMD;
                    end
                end
                ST_FIN: begin
                    spi_cs_n  <= 1'b1;
                    spi_sclk  <= 1'b0;
                    bus_ready <= 1'b1;
                    bus_rdata <= rsr;
                    state     <= ST_IDLE;
                end
                default: begin
                    if (tick && !spi_sclk) begin
                        spi_sclk <= 1'b1;
                        rx       <= rx_next;
                        bit_cnt  <= last_bit ? 3'd0 : bit_cnt + 3'd1;
                        byte_end <= last_bit;
                        if (last_bit && state == ST_DATA && !lat_we)
                            rsr <= {rx_next, rsr[DATA_W-1:8]};
                        if (last_bit && state == ST_DATA &&
                            byte_cnt == CNT_W'(DATA_BYTES - 1))
                            state <= ST_FIN;
                    end else if (tick) begin
                        spi_sclk <= 1'b0;
                        if (byte_end) begin
                            byte_end <= 1'b0;
                            case (state)
                                ST_CMD: begin
                                    state    <= ST_ADDR;
                                    byte_cnt <= '0;
                                    sr       <= addr_sr[ADDR_W-1 -: 8];
                                    addr_sr  <= addr_sr << 8;
                                end
                                ST_ADDR: begin
                                    if (byte_cnt != CNT_W'(lat_alen)) begin
                                        byte_cnt <= byte_cnt + CNT_W'(1);
                                        sr       <= addr_sr[ADDR_W-1 -: 8];
                                        addr_sr  <= addr_sr << 8;
                                    end else if (lat_dummy != '0) begin
                                        state    <= ST_DUMMY;
                                        byte_cnt <= '0;
                                        sr       <= 8'h00;
                                    end else begin
                                        state    <= ST_DATA;
                                        byte_cnt <= '0;
                                        sr       <= lat_we ? wsr[7:0] : 8'h00;
                                        wsr      <= wsr >> 8;
                                    end
                                end
                                ST_DUMMY: begin
                                    if (byte_cnt == CNT_W'(lat_dummy - DUMMY_W'(1))) begin
                                        state    <= ST_DATA;
                                        byte_cnt <= '0;
                                        sr       <= lat_we ? wsr[7:0] : 8'h00;
                                        wsr      <= wsr >> 8;
                                    end else begin
                                        byte_cnt <= byte_cnt + CNT_W'(1);
                                        sr       <= 8'h00;
                                    end
                                end
                                default: begin
                                    byte_cnt <= byte_cnt + CNT_W'(1);
                                    sr       <= lat_we ? wsr[7:0] : 8'h00;
                                    wsr      <= wsr >> 8;
                                end
                            endcase
                        end else begin
                            sr <= {sr[6:0], 1'b0};
                        end
                    end
                end
            endcase
        end
    end

    // R7
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    // R7
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> (spi_cs_n && !$past(spi_cs_n)));

    // R8
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R6
    lane_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(spi_doe) && (spi_cs_n ? (spi_doe == 4'b0000) : 1'b1));
endmodule

// File: rtl/spi_flash_mmap.sv
// Top of the SPI flash memory-mapped access engine: joins the sequencer
// with the serial clock tick generator. Assumes one request at a time,
// with bus_req held until bus_ready.
module spi_flash_mmap #(
    parameter int DATA_BYTES = 4,
    parameter int DUMMY_W    = 4,
    parameter int DIV_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              cfg_rd_cmd,
    input  logic [7:0]              cfg_wr_cmd,
    input  logic [1:0]              cfg_addr_len,
    input  logic [DUMMY_W-1:0]      cfg_dummy,
    input  logic                    cfg_quad_rd,
    input  logic [DIV_W-1:0]        cfg_clk_div,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [31:0]             bus_addr,
    input  logic [8*DATA_BYTES-1:0] bus_wdata,
    output logic [8*DATA_BYTES-1:0] bus_rdata,
    output logic                    bus_ready,
    output logic                    spi_cs_n,
    output logic                    spi_sclk,
    output logic [3:0]              spi_dout,
    output logic [3:0]              spi_doe,
    input  logic [3:0]              spi_din
);
    logic             tick;
    logic             run;
    logic [DIV_W-1:0] lat_div;

    sfm_seq #(
        .DATA_BYTES(DATA_BYTES),
        .DUMMY_W   (DUMMY_W),
        .DIV_W     (DIV_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_rd_cmd  (cfg_rd_cmd),
        .cfg_wr_cmd  (cfg_wr_cmd),
        .cfg_addr_len(cfg_addr_len),
        .cfg_dummy   (cfg_dummy),
        .cfg_quad_rd (cfg_quad_rd),
        .cfg_clk_div (cfg_clk_div),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_ready   (bus_ready),
        .spi_cs_n    (spi_cs_n),
        .spi_sclk    (spi_sclk),
        .spi_dout    (spi_dout),
        .spi_doe     (spi_doe),
        .spi_din     (spi_din),
        .tick        (tick),
        .run         (run),
        .lat_div     (lat_div)
    );

    sfm_clkdiv #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .div  (lat_div),
        .tick (tick)
    );
endmodule

// File: tb/spi_flash_mmap_tb.sv
// Bench for spi_flash_mmap: a behavioural flash model on the lanes, with
// directed corner cases and seeded random accesses checked against models.
module spi_flash_mmap_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_rd_cmd = '0, cfg_wr_cmd = '0;
    logic [1:0]  cfg_addr_len = '0;
    logic [3:0]  cfg_dummy = '0;
    logic        cfg_quad_rd = 1'b0;
    logic [7:0]  cfg_clk_div = '0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready, spi_cs_n, spi_sclk;
    logic [3:0]  spi_dout, spi_doe;
    logic [3:0]  din_r = '0;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    spi_flash_mmap u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_rd_cmd(cfg_rd_cmd), .cfg_wr_cmd(cfg_wr_cmd),
        .cfg_addr_len(cfg_addr_len), .cfg_dummy(cfg_dummy),
        .cfg_quad_rd(cfg_quad_rd), .cfg_clk_div(cfg_clk_div),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_dout(spi_dout),
        .spi_doe(spi_doe), .spi_din(din_r)
    );

    // Transaction context seen by the flash model.
    bit          t_we, t_quad;
    int          t_alen, t_dummy, t_div, hdr;
    logic [31:0] t_addrm;

    // Wire monitor state.
    logic [7:0]  txb [0:63];
    int cyc = 0, ti = 0, nrise = 0, cs_fall = 0, first_rise = 0, last_rise = 0;
    int gap_bad = 0, doe_bad = 0, idle_bad = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b0;

    function automatic logic [7:0] fmem(input logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'hA5;
    endfunction

    function automatic logic [3:0] din_for(input int n);
        int d;
        logic [7:0] b;
        if (n < hdr) return 4'b0000;
        d = n - hdr;
        if (t_quad && !t_we) begin
            b = fmem(t_addrm + 32'(d / 2));
            return (d % 2 == 0) ? b[7:4] : b[3:0];
        end
        b = fmem(t_addrm + 32'(d / 8));
        return {2'b00, b[7 - (d % 8)], 1'b0};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Flash model: capture lane 0 on rising sclk, drive input lanes while low.
    always @(negedge clk) begin
        cyc++;
        if (prev_cs && !spi_cs_n) begin
            ti = 0; nrise = 0; cs_fall = cyc; gap_bad = 0; doe_bad = 0;
        end
        if (spi_cs_n && spi_sclk) idle_bad++;
        if (!spi_cs_n && spi_sclk && !prev_sclk) begin
            if (ti < 512) txb[ti / 8][7 - (ti % 8)] = spi_dout[0];
            ti++;
            if (nrise == 0) first_rise = cyc;
            else if (cyc - last_rise != 2 * (t_div + 1)) gap_bad++;
            last_rise = cyc;
            nrise++;
        end
        if (!spi_cs_n && spi_sclk) begin
            if (spi_doe != ((t_quad && !t_we && nrise > hdr) ? 4'b0000 : 4'b0001))
                doe_bad++;
        end
        if (!spi_sclk) din_r = din_for(nrise);
        prev_cs = spi_cs_n;
        prev_sclk = spi_sclk;
    end

    // One access, driven from just after a falling clock edge, then checked.
    task automatic run(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                       input int alen, input int dmy, input bit quad, input int div,
                       input bit scramble, input bit keep);
        logic [7:0]  rc, wc;
        logic [31:0] gotv, expv;
        logic [7:0]  dz;
        int n, exp_n;
        rc = 8'($urandom); wc = 8'($urandom);
        t_we = we; t_quad = quad; t_alen = alen; t_dummy = dmy; t_div = div;
        hdr = (2 + alen + dmy) * 8;
        t_addrm = (alen == 3) ? addr : (addr & ((32'h1 << (8 * (alen + 1))) - 32'h1));
        cfg_rd_cmd = rc; cfg_wr_cmd = wc; cfg_addr_len = 2'(alen);
        cfg_dummy = 4'(dmy); cfg_quad_rd = quad; cfg_clk_div = 8'(div);
        bus_we = we; bus_addr = addr; bus_wdata = wd; bus_req = 1'b1;
        n = 0;
        do begin
            @(negedge clk); #1;
            n++;
            if (n == 1 && scramble) begin
                cfg_rd_cmd = ~rc; cfg_wr_cmd = ~wc; cfg_addr_len = 2'(alen + 1);
                cfg_dummy = 4'(dmy + 3); cfg_quad_rd = !quad; cfg_clk_div = 8'(div + 2);
                bus_addr = ~addr; bus_wdata = ~wd; bus_we = !we;
            end
        end while (!bus_ready && n < 40000);
        if (!bus_ready) begin
            chk(1'b0, "R7", "no ready", 0, 1);
            bus_req = 1'b0;
            return;
        end
        // R1 / R11: command byte from the captured direction and config.
        chk(txb[0] == (we ? wc : rc), scramble ? "R11" : "R1", "command",
            txb[0], we ? wc : rc);
        // R2: address bytes, most significant first.
        gotv = '0;
        for (int i = 0; i <= alen; i++) gotv = (gotv << 8) | 32'(txb[1 + i]);
        expv = t_addrm;
        chk(gotv == expv, "R2", "address", gotv, expv);
        // R3: dummy bytes are zero and the edge count matches.
        dz = '0;
        for (int j = 0; j < dmy; j++) dz = dz | txb[2 + alen + j];
        chk(dz == 8'h00, "R3", "dummy content", dz, 0);
        exp_n = hdr + ((quad && !we) ? 2 : 8) * 4;
        chk(nrise == exp_n, scramble ? "R11" : "R3", "rising edges", nrise, exp_n);
        if (we) begin
            // R4: write bytes, lowest byte first.
            gotv = '0;
            for (int k = 0; k < 4; k++) gotv[8*k +: 8] = txb[hdr / 8 + k];
            chk(gotv == wd, "R4", "write data", gotv, wd);
        end else begin
            expv = '0;
            for (int k = 0; k < 4; k++) expv[8*k +: 8] = fmem(t_addrm + 32'(k));
            chk(bus_rdata == expv, quad ? "R6" : "R5", "read data", bus_rdata, expv);
        end
        // R6: lane directions during the whole access.
        chk(doe_bad == 0, "R6", "lane enables", doe_bad, 0);
        // R7: ready one cycle after the last rising edge, with cs released.
        chk(cyc - last_rise == 1 && spi_cs_n, "R7", "ready timing",
            cyc - last_rise, 1);
        // R9: divider timing.
        chk(first_rise - cs_fall == div + 1, "R9", "first edge delay",
            first_rise - cs_fall, div + 1);
        chk(gap_bad == 0, "R9", "edge spacing", gap_bad, 0);
        if (!keep) begin
            bus_req = 1'b0;
            @(negedge clk); #1;
            chk(!bus_ready, "R7", "ready width", bus_ready, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        repeat (5) @(negedge clk);
        #1;
        // R10: reset state.
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && bus_ready == 1'b0 && spi_doe == 4'b0000,
            "R10", "reset outputs", {spi_cs_n, spi_sclk, bus_ready, spi_doe}, 7'b1000000);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(spi_cs_n && !spi_sclk, "R10", "idle after reset", {spi_cs_n, spi_sclk}, 2'b10);

        // Directed corner cases.
        run(1'b0, 32'h12345678, 32'h0, 3, 0, 1'b0, 0, 1'b0, 1'b0);
        run(1'b0, 32'hABCDEF01, 32'h0, 2, 1, 1'b1, 1, 1'b0, 1'b0);
        run(1'b1, 32'h000000C3, 32'hDEADBEEF, 0, 0, 1'b1, 0, 1'b0, 1'b0);
        run(1'b0, 32'h00FF00FF, 32'h0, 1, 15, 1'b1, 2, 1'b0, 1'b0);
        run(1'b1, 32'h89ABCDEF, 32'h01234567, 3, 2, 1'b0, 3, 1'b0, 1'b0);
        // R11: inputs scrambled right after acceptance.
        run(1'b0, 32'h5A5AA5A5, 32'h0, 2, 2, 1'b1, 1, 1'b1, 1'b0);
        run(1'b1, 32'h11223344, 32'hCAFEF00D, 1, 1, 1'b0, 0, 1'b1, 1'b0);
        // Back to back: request held over the ready pulse.
        run(1'b1, 32'h00A0B0C0, 32'h76543210, 2, 0, 1'b0, 0, 1'b0, 1'b1);
        run(1'b0, 32'h00A0B0C0, 32'h0, 2, 0, 1'b1, 0, 1'b0, 1'b1);
        run(1'b0, 32'h00000010, 32'h0, 0, 3, 1'b0, 1, 1'b0, 1'b0);

        // Seeded random accesses.
        for (int r = 0; r < 40; r++) begin
            run(1'($urandom), $urandom, $urandom, int'($urandom % 4), int'($urandom % 6),
                1'($urandom), int'($urandom % 4), 1'b0, 1'($urandom % 5 == 0));
        end
        bus_req = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        // R8: sclk never high while chip select is released.
        chk(idle_bad == 0, "R8", "sclk high with cs released", idle_bad, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule